// File: doc/BRIEF.md
# Four-Register Single-Cycle 8-bit Processor

This block is a minimal processor core that completes one instruction on every clock edge. Its architectural state is four 8-bit general registers and a 6-bit program counter. Instructions are 12 bits wide and come from a separate 64-entry instruction store. Data lives in a separate 64-byte data store that the core reads combinationally and writes on the clock edge.

The instruction set has five operations: a three-register add, a byte load and a byte store that both use a base register plus a small signed displacement, a branch taken when two registers are equal, and an absolute jump. The remaining three opcodes do nothing except advance the program counter. There are no flags, no carries and no traps. Every sum wraps silently.

A debug port shows the whole register file and the program counter at all times. An environment can therefore compare the architectural state against a behavioural model after each instruction.

Top module: `tiny8_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four registers become 0 and the program counter becomes 0; `dmem_we` stays low while `rst_n` is low.
- R2: The add, load, store and no-op instructions set the program counter to PC+1 modulo 64, so 63 is followed by 0.
- R3: Instruction word layout is opcode [11:9], field A [8:7], field B [6:5], field C [4:3], displacement [2:0] (two's complement). Opcode 000 (add) writes (reg[B] + reg[C]) mod 256 into reg[A] and does not write memory.
- R4: Opcode 001 (load) writes mem[(reg[B] + sext(disp)) mod 64] into reg[A]. The address uses the low 6 bits of reg[B].
- R5: Opcode 010 (store) writes reg[A] to mem[(reg[B] + sext(disp)) mod 64] and leaves all registers unchanged.
- R6: Opcode 011 (branch) with reg[A] == reg[B] sets the program counter to (PC + 1 + sext(disp)) mod 64.
- R7: Opcode 011 with reg[A] != reg[B] sets the program counter to PC+1 mod 64. A branch never changes a register or memory.
- R8: Opcode 100 (jump) loads the program counter with instruction bits [5:0] and changes no register and no memory.
- R9: Opcodes 101, 110 and 111 change no register and no memory.
- R10: `imem_addr` always equals the current program counter. `dbg_regs[8*i +: 8]` shows register i, and `dbg_pc` shows the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 6 | Fetch address (the program counter) |
| imem_data | input | 12 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 6 | Data address for load and store |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Store strobe; memory written at the rising edge |
| dmem_rdata | input | 8 | Load data at `dmem_addr`, valid in the same cycle |
| dbg_pc | output | 6 | Current program counter |
| dbg_regs | output | 32 | Register file, register i in bits [8*i+7:8*i] |

## Verification
The assertions assume two things about the memories. First, `imem_data` and `dmem_rdata` are settled combinational functions of the addresses the core drives in the same cycle. Second, the data store is written only on an edge where `dmem_we` is high. The bench models both stores as arrays that it indexes directly and writes only on `dmem_we`, so those conditions hold. Every instruction word it generates comes from the 12-bit format, including the three unused opcodes. Reset changes only on falling edges, so no property attempt begins across a half-applied reset.

// File: rtl/tiny8_pkg.sv
// tiny8_pkg: shared widths, opcodes and the decoded-control record for the
// four-register core. Assumes DATA_W >= ADDR_W so a register can form an address.
package tiny8_pkg;
    parameter int DATA_W = 8;
    parameter int NREG   = 4;
    parameter int ADDR_W = 6;
    parameter int OFF_W  = 3;
    parameter int OP_W   = 3;

    localparam int RSEL_W = $clog2(NREG);
    localparam int INSN_W = OP_W + 3 * RSEL_W + OFF_W;
    localparam int FC_LSB = OFF_W;
    localparam int FB_LSB = FC_LSB + RSEL_W;
    localparam int FA_LSB = FB_LSB + RSEL_W;
    localparam int OP_LSB = FA_LSB + RSEL_W;

    localparam logic [OP_W-1:0] OPC_ADD = 3'd0;
    localparam logic [OP_W-1:0] OPC_LD  = 3'd1;
    localparam logic [OP_W-1:0] OPC_ST  = 3'd2;
    localparam logic [OP_W-1:0] OPC_BEQ = 3'd3;
    localparam logic [OP_W-1:0] OPC_JMP = 3'd4;

    typedef struct packed {
        logic              reg_we;
        logic              load;
        logic              store;
        logic              branch;
        logic              jump;
        logic [RSEL_W-1:0] dst;
        logic [RSEL_W-1:0] src_a;
        logic [RSEL_W-1:0] src_b;
        logic [ADDR_W-1:0] ofs;
        logic [ADDR_W-1:0] target;
    } ctrl_t;
endpackage

// File: rtl/tiny8_decode.sv
// tiny8_decode: turns one instruction word into a control record.
// Purely combinational; opcodes outside the five defined ones decode to
// a record that writes nothing and does not redirect the PC.
module tiny8_decode
    import tiny8_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output ctrl_t             ctl
);
    logic [OP_W-1:0]   opc;
    logic [RSEL_W-1:0] fa, fb, fc;
    logic [OFF_W-1:0]  disp;

    assign opc  = insn[OP_LSB +: OP_W];
    assign fa   = insn[FA_LSB +: RSEL_W];
    assign fb   = insn[FB_LSB +: RSEL_W];
    assign fc   = insn[FC_LSB +: RSEL_W];
    assign disp = insn[OFF_W-1:0];

    // Classify the opcode and route register fields per operation.
    always_comb begin
        ctl        = '0;
        ctl.ofs    = {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
        ctl.target = insn[ADDR_W-1:0];
        ctl.src_a  = fb;
        ctl.src_b  = fc;
        ctl.dst    = fa;
        case (opc)
            OPC_ADD: ctl.reg_we = 1'b1;
            OPC_LD: begin
                ctl.reg_we = 1'b1;
                ctl.load   = 1'b1;
            end
            OPC_ST: begin
                ctl.store = 1'b1;
                ctl.src_b = fa;
            end
            OPC_BEQ: begin
                ctl.branch = 1'b1;
                ctl.src_a  = fa;
                ctl.src_b  = fb;
            end
            OPC_JMP: ctl.jump = 1'b1;
            default: ;
        endcase
    end

    // Check that at most one operation class is active for any word.
    always_comb begin
        // R9
        ctrl_class_chk: assert ($onehot0({ctl.load, ctl.store, ctl.branch, ctl.jump}) &&
                                !(ctl.reg_we && (ctl.store || ctl.branch || ctl.jump)));
    end
endmodule

// File: rtl/tiny8_regfile.sv
// tiny8_regfile: NREG x DATA_W registers, two combinational read ports and one
// write port. Synchronous active-low reset clears every entry and takes
// priority over a write. The whole file is also presented flat for debug.
module tiny8_regfile
    import tiny8_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [RSEL_W-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [RSEL_W-1:0]      raddr_a,
    input  logic [RSEL_W-1:0]      raddr_b,
    output logic [DATA_W-1:0]      rdata_a,
    output logic [DATA_W-1:0]      rdata_b,
    output logic [NREG*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold, clear or load register i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && waddr == RSEL_W'(i))
                regs[i] <= wdata;
        end
        assign flat[i*DATA_W +: DATA_W] = regs[i];
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R5
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> flat == $past(flat));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tiny8_nextpc.sv
// tiny8_nextpc: chooses the following program counter from sequential,
// taken-branch and jump candidates. All arithmetic wraps in ADDR_W bits.
module tiny8_nextpc
    import tiny8_pkg::*;
(
    input  logic [ADDR_W-1:0] pc,
    input  logic              branch,
    input  logic              jump,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] ofs,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] br_pc;
    logic              equal;

    assign seq_pc = pc + ADDR_W'(1);
    assign br_pc  = seq_pc + ofs;
    assign equal  = (opnd_a == opnd_b);

    // Select jump, taken branch or fall-through.
    always_comb begin
        if (jump)
            next_pc = target;
        else if (branch && equal)
            next_pc = br_pc;
        else
            next_pc = seq_pc;
    end
endmodule

// File: rtl/tiny8_core.sv
// tiny8_core: single-cycle core. Fetch, decode, register read, address or
// sum, memory access and write-back all complete between two rising edges.
// Assumes both stores answer combinationally in the cycle they are addressed.
module tiny8_core
    import tiny8_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [ADDR_W-1:0]      imem_addr,
    input  logic [INSN_W-1:0]      imem_data,
    output logic [ADDR_W-1:0]      dmem_addr,
    output logic [DATA_W-1:0]      dmem_wdata,
    output logic                   dmem_we,
    input  logic [DATA_W-1:0]      dmem_rdata,
    output logic [ADDR_W-1:0]      dbg_pc,
    output logic [NREG*DATA_W-1:0] dbg_regs
);
    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc, pc_nxt;
    logic [DATA_W-1:0] rd_a, rd_b, wb_data;

    tiny8_decode u_dec (
        .insn (imem_data),
        .ctl  (ctl)
    );

    tiny8_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.reg_we),
        .waddr   (ctl.dst),
        .wdata   (wb_data),
        .raddr_a (ctl.src_a),
        .raddr_b (ctl.src_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .flat    (dbg_regs)
    );

    tiny8_nextpc u_npc (
        .pc      (pc),
        .branch  (ctl.branch),
        .jump    (ctl.jump),
        .opnd_a  (rd_a),
        .opnd_b  (rd_b),
        .ofs     (ctl.ofs),
        .target  (ctl.target),
        .next_pc (pc_nxt)
    );

    // Advance the program counter, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_nxt;
    end

    // Pick write-back data: loaded byte or register sum.
    always_comb begin
        wb_data = ctl.load ? dmem_rdata : rd_a + rd_b;
    end

    assign imem_addr  = pc;
    assign dbg_pc     = pc;
    assign dmem_addr  = rd_a[ADDR_W-1:0] + ctl.ofs;
    assign dmem_wdata = rd_b;
    assign dmem_we    = ctl.store & rst_n;

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.branch && !ctl.jump) |=> pc == $past(pc) + ADDR_W'(1));

    // R7
    fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && rd_a != rd_b) |=> pc == $past(pc) + ADDR_W'(1));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump |=> pc == $past(imem_data[ADDR_W-1:0]));

    // R5
    store_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> dbg_regs == $past(dbg_regs));
endmodule

// File: tb/tiny8_core_tb.sv
module tiny8_core_tb;
    import tiny8_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [ADDR_W-1:0]      imem_addr, dmem_addr, dbg_pc;
    logic [INSN_W-1:0]      imem_data;
    logic [DATA_W-1:0]      dmem_wdata, dmem_rdata;
    logic                   dmem_we;
    logic [NREG*DATA_W-1:0] dbg_regs;

    logic [INSN_W-1:0] imem [64];
    logic [DATA_W-1:0] dmem [64];

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    tiny8_core u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
    );

    // reference model state
    logic [7:0] m_reg [4];
    logic [7:0] m_mem [64];
    logic [5:0] m_pc;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] enc(input int op, input int a, input int b, input int c, input int d);
        return {3'(op), 2'(a), 2'(b), 2'(c), 3'(d)};
    endfunction

    function automatic logic [31:0] model_regs();
        return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
    endfunction

    task automatic compare(input string rtag, input string ptag);
        int bad = -1;
        chk(ptag, "pc", int'(dbg_pc), int'(m_pc));
        chk("R10", "fetch address", int'(imem_addr), int'(m_pc));
        chk(rtag, "registers", int'(dbg_regs), int'(model_regs()));
        for (int k = 0; k < 64; k++) if (bad < 0 && dmem[k] !== m_mem[k]) bad = k;
        if (bad >= 0) chk(rtag, $sformatf("mem[%0d]", bad), int'(dmem[bad]), int'(m_mem[bad]));
        else chk(rtag, "memory", 0, 0);
    endtask

    // execute one instruction in the model and in the design, then compare
    task automatic step();
        logic [11:0] w;
        logic [2:0] op;
        logic [1:0] a, b, c;
        logic [5:0] sx, ea;
        string rtag, ptag;
        w  = imem[m_pc];
        op = w[11:9]; a = w[8:7]; b = w[6:5]; c = w[4:3];
        sx = {{3{w[2]}}, w[2:0]};
        ea = m_reg[b][5:0] + sx;
        ptag = "R2";
        case (op)
            3'd0: begin rtag = "R3"; m_reg[a] = m_reg[b] + m_reg[c]; m_pc = m_pc + 6'd1; end
            3'd1: begin rtag = "R4"; m_reg[a] = m_mem[ea]; m_pc = m_pc + 6'd1; end
            3'd2: begin rtag = "R5"; m_mem[ea] = m_reg[a]; m_pc = m_pc + 6'd1; end
            3'd3: begin
                if (m_reg[a] == m_reg[b]) begin rtag = "R6"; ptag = "R6"; m_pc = m_pc + 6'd1 + sx; end
                else begin rtag = "R7"; ptag = "R7"; m_pc = m_pc + 6'd1; end
            end
            3'd4: begin rtag = "R8"; ptag = "R8"; m_pc = w[5:0]; end
            default: begin rtag = "R9"; m_pc = m_pc + 6'd1; end
        endcase
        @(posedge clk); @(negedge clk);
        compare(rtag, ptag);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 4; k++) m_reg[k] = 8'd0;
        m_pc = 6'd0;
        // R1: reset state, memory untouched during reset
        compare("R1", "R1");
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    initial begin
        @(negedge clk);
        for (int k = 0; k < 64; k++) begin
            imem[k]  = enc(6, 0, 0, 0, 0);
            dmem[k]  = 8'((k * 29 + 7) & 255);
            m_mem[k] = 8'((k * 29 + 7) & 255);
        end
        imem[0]  = enc(1, 1, 0, 0, 3);   // lw r1, 3(r0)  -> 94
        imem[1]  = enc(1, 2, 0, 0, 7);   // lw r2, -1(r0) -> addr 63 -> 42
        imem[2]  = enc(0, 3, 1, 1, 0);   // add r3 = 188
        imem[3]  = enc(0, 3, 3, 3, 0);   // add r3 = 376 mod 256 = 120
        imem[4]  = enc(2, 3, 1, 0, 2);   // sw r3 -> (94 mod 64)+2 = 32
        imem[5]  = enc(3, 0, 1, 0, 3);   // beq not taken
        imem[6]  = {3'd4, 3'd0, 6'd10};  // j 10
        imem[10] = enc(3, 0, 0, 0, 4);   // beq taken, 11-4 = 7
        imem[7]  = {3'd4, 3'd0, 6'd62};  // j 62
        imem[62] = enc(5, 3, 3, 3, 7);   // no-op
        imem[63] = enc(7, 3, 3, 3, 7);   // no-op, wraps to 0
        do_reset(3);
        rst_n = 1'b1;
        for (int i = 0; i < 11; i++) step();
        chk("R3", "add wrap r3", int'(dbg_regs[31:24]), (2 * 2 * 94) % 256);
        chk("R4", "load wrapped address r2", int'(dbg_regs[23:16]), (63 * 29 + 7) % 256);
        chk("R5", "store at wrapped address", int'(dmem[32]), (2 * 2 * 94) % 256);
        chk("R2", "pc wrap 63 to 0", int'(dbg_pc), 0);
        do_reset(2);
        chk("R1", "regs cleared mid-run", int'(dbg_regs), 0);
        for (int p = 0; p < 20; p++) begin
            for (int k = 0; k < 64; k++) imem[k] = rnd() & 32'hfff;
            rst_n = 1'b1;
            for (int i = 0; i < 150; i++) step();
            do_reset(1);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule